// File: doc/BRIEF.md
# Disk Task-File Address Registers

This block is the device-side register file that holds the starting sector address and the sector count of a host block read or write. The host writes the registers one byte at a time. Each register is a two-deep byte stack, so a 48-bit address and a 16-bit count can be loaded through 8-bit ports: writing the same register twice leaves the high-order byte in the "previous" slot and the low-order byte in the "current" slot. A high-order-byte select on the read side returns either slot.

When the command engine accepts a command, the block decodes the stack contents into a starting LBA and a transfer count. A count of zero decodes to the largest transfer of the addressing mode. The block then holds these values steady while the command runs. At command end the engine hands back the address it reached and the number of sectors left, and the block writes them into the registers for the host to read.

Control is a three-state machine. `ST_IDLE` is the only state that accepts host writes. The transition *accept* (cmd_start seen in `ST_IDLE`) latches the decoded values and enters `ST_RUN`. In `ST_RUN` the registers are frozen. The transition *finish* (cmd_done seen in `ST_RUN`) captures the progress values and enters `ST_WRBACK`. `ST_WRBACK` writes the progress into the stacks and takes the unconditional transition *release* back to `ST_IDLE` on the next edge.

Top module: `tf_addr_regs`

## Requirements
- R1: After reset every slot of every register reads 0x00, busy is 0 and xfer_count is 0.
- R2: In ST_IDLE, a host_wr pulse without cmd_start in the same cycle moves the current byte of the selected register into its previous slot and stores host_wdata as the new current byte, visible after that edge.
- R3: host_rdata shows the current byte of the register selected by host_sel when host_hob is 0, and its previous byte when host_hob is 1. The host_sel codes are 0 = count, 1 = LBA low, 2 = LBA mid, 3 = LBA high.
- R4: In 28-bit mode (cmd_ext 0 at accept), start_lba after the accept edge is {dev_head[3:0], high.cur, mid.cur, low.cur} zero-extended to 48 bits, and busy is 1.
- R5: In 48-bit mode (cmd_ext 1 at accept), start_lba is {high.prev, mid.prev, low.prev, high.cur, mid.cur, low.cur}, and dev_head has no effect.
- R6: In 28-bit mode xfer_count equals count.cur, and a value of 0 gives 256.
- R7: In 48-bit mode xfer_count equals {count.prev, count.cur}, and a value of 0 gives 65536.
- R8: A host write in the same cycle as an accepted cmd_start, or at any time while busy, changes no register.
- R9: A cmd_done seen in ST_RUN moves to ST_WRBACK on that edge and to ST_IDLE on the next edge. busy drops after that second edge.
- R10: Write-back in 48-bit mode sets the current slots to done_lba bits 7:0, 15:8, 23:16 and done_remain bits 7:0. It sets the previous slots to done_lba bits 31:24, 39:32, 47:40 and done_remain bits 15:8, register by register.
- R11: Write-back in 28-bit mode sets only the current slots to done_lba bits 7:0, 15:8, 23:16 and done_remain bits 7:0. The previous slots keep their values.
- R12: start_lba and xfer_count do not change while busy. A cmd_start while busy and a cmd_done while idle are both ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host byte write strobe |
| host_sel | input | 2 | Register select: 0 count, 1 LBA low, 2 LBA mid, 3 LBA high |
| host_wdata | input | 8 | Host write byte |
| host_hob | input | 1 | Read previous slot instead of current |
| host_rdata | output | 8 | Read byte (combinational) |
| dev_head | input | 4 | Device/head nibble, supplies LBA bits 27:24 in 28-bit mode |
| cmd_start | input | 1 | Command accepted by the engine |
| cmd_ext | input | 1 | 1 selects 48-bit addressing for this command |
| cmd_done | input | 1 | Command ended; progress values are valid |
| done_lba | input | 48 | Address reached at command end |
| done_remain | input | 16 | Sectors still to transfer (0 on success) |
| busy | output | 1 | Command in progress (ST_RUN or ST_WRBACK) |
| start_lba | output | 48 | Decoded starting address |
| xfer_count | output | 17 | Decoded sector count |

## Verification
Host writes take effect on the edge that samples them, so the bench drives on a falling edge and reads back at the next falling edge. start_lba, xfer_count and busy are registered on the accept edge and are checked half a cycle later. Write-back lands one edge after finish: busy is checked still high one falling edge after cmd_done, and the register contents are checked only at the following falling edge, once the ST_WRBACK edge has passed.

// File: rtl/tf_pkg.sv
package tf_pkg;
    localparam int BYTE_W = 8;
    localparam int HEAD_W = 4;
    localparam int NREG   = 4;
    localparam int IDX_CNT = 0;
    localparam int IDX_LO  = 1;
    localparam int IDX_MID = 2;
    localparam int IDX_HI  = 3;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_WRBACK = 2'd2
    } tf_state_e;
endpackage

// File: rtl/tf_byte_stack.sv
module tf_byte_stack #(
    parameter int BYTE_W = tf_pkg::BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [BYTE_W-1:0] host_wdata,
    input  logic              wb_en,
    input  logic              wb_both,
    input  logic [BYTE_W-1:0] wb_cur,
    input  logic [BYTE_W-1:0] wb_prev,
    output logic [BYTE_W-1:0] cur,
    output logic [BYTE_W-1:0] prev
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur  <= '0;
            prev <= '0;
        end else if (wb_en) begin
            cur <= wb_cur;
            if (wb_both) begin
                prev <= wb_prev;
            end
        end else if (host_we) begin
            prev <= cur;
            cur  <= host_wdata;
        end
    end
endmodule

// File: rtl/tf_start_decode.sv
module tf_start_decode #(
    parameter int BYTE_W = tf_pkg::BYTE_W,
    parameter int HEAD_W = tf_pkg::HEAD_W,
    parameter int NREG   = tf_pkg::NREG
) (
    input  logic                        ext,
    input  logic [HEAD_W-1:0]           head,
    input  logic [NREG-1:0][BYTE_W-1:0] cur,
    input  logic [NREG-1:0][BYTE_W-1:0] prev,
    output logic [6*BYTE_W-1:0]         lba,
    output logic [2*BYTE_W:0]           count
);
    import tf_pkg::*;
    localparam int CNT_W = 2 * BYTE_W;

    logic [CNT_W-1:0] wide_cnt;

    always_comb begin
        lba      = '0;
        count    = '0;
        wide_cnt = {prev[IDX_CNT], cur[IDX_CNT]};
        if (ext) begin
            lba = {prev[IDX_HI], prev[IDX_MID], prev[IDX_LO],
                   cur[IDX_HI],  cur[IDX_MID],  cur[IDX_LO]};
            if (wide_cnt == '0) begin
                count[CNT_W] = 1'b1;
            end else begin
                count[CNT_W-1:0] = wide_cnt;
            end
        end else begin
            lba[3*BYTE_W-1:0]        = {cur[IDX_HI], cur[IDX_MID], cur[IDX_LO]};
            lba[3*BYTE_W +: HEAD_W]  = head;
            if (cur[IDX_CNT] == '0) begin
                count[BYTE_W] = 1'b1;
            end else begin
                count[BYTE_W-1:0] = cur[IDX_CNT];
            end
        end
    end
endmodule

// File: rtl/tf_ctrl.sv
module tf_ctrl (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic              cmd_done,
    output tf_pkg::tf_state_e st,
    output logic              accept,
    output logic              finish,
    output logic              wb_en,
    output logic              host_open,
    output logic              busy
);
    import tf_pkg::*;

    tf_state_e st_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nxt;
        end
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE:   if (cmd_start) st_nxt = ST_RUN;
            ST_RUN:    if (cmd_done)  st_nxt = ST_WRBACK;
            ST_WRBACK: st_nxt = ST_IDLE;
            default:   st_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        accept    = 1'b0;
        finish    = 1'b0;
        wb_en     = 1'b0;
        host_open = 1'b0;
        busy      = 1'b0;
        unique case (st)
            ST_IDLE: begin
                accept    = cmd_start;
                host_open = !cmd_start;
            end
            ST_RUN: begin
                busy   = 1'b1;
                finish = cmd_done;
            end
            ST_WRBACK: begin
                busy  = 1'b1;
                wb_en = 1'b1;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/tf_addr_regs.sv
module tf_addr_regs #(
    parameter int BYTE_W = tf_pkg::BYTE_W,
    parameter int HEAD_W = tf_pkg::HEAD_W,
    parameter int SEL_W  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_wr,
    input  logic [SEL_W-1:0]    host_sel,
    input  logic [BYTE_W-1:0]   host_wdata,
    input  logic                host_hob,
    output logic [BYTE_W-1:0]   host_rdata,
    input  logic [HEAD_W-1:0]   dev_head,
    input  logic                cmd_start,
    input  logic                cmd_ext,
    input  logic                cmd_done,
    input  logic [6*BYTE_W-1:0] done_lba,
    input  logic [2*BYTE_W-1:0] done_remain,
    output logic                busy,
    output logic [6*BYTE_W-1:0] start_lba,
    output logic [2*BYTE_W:0]   xfer_count
);
    import tf_pkg::*;
    localparam int NR    = 1 << SEL_W;
    localparam int LBA_W = 6 * BYTE_W;
    localparam int CNT_W = 2 * BYTE_W;

    tf_state_e st;
    logic      accept, finish, wb_en, host_open;
    logic      mode_ext;

    logic [NR-1:0][BYTE_W-1:0] cur_q, prev_q, wb_cur, wb_prev;
    logic [LBA_W-1:0]          dec_lba, done_lba_q;
    logic [CNT_W:0]            dec_cnt;
    logic [CNT_W-1:0]          done_rem_q;

    tf_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_start (cmd_start),
        .cmd_done  (cmd_done),
        .st        (st),
        .accept    (accept),
        .finish    (finish),
        .wb_en     (wb_en),
        .host_open (host_open),
        .busy      (busy)
    );

    for (genvar i = 0; i < NR; i++) begin : g_reg
        if (i == IDX_CNT) begin : g_cnt
            assign wb_cur[i]  = done_rem_q[BYTE_W-1:0];
            assign wb_prev[i] = done_rem_q[CNT_W-1:BYTE_W];
        end else begin : g_lba
            assign wb_cur[i]  = done_lba_q[(i-1)*BYTE_W +: BYTE_W];
            assign wb_prev[i] = done_lba_q[(i+2)*BYTE_W +: BYTE_W];
        end

        tf_byte_stack #(.BYTE_W(BYTE_W)) u_stack (
            .clk        (clk),
            .rst_n      (rst_n),
            .host_we    (host_open && host_wr && (host_sel == SEL_W'(i))),
            .host_wdata (host_wdata),
            .wb_en      (wb_en),
            .wb_both    (mode_ext),
            .wb_cur     (wb_cur[i]),
            .wb_prev    (wb_prev[i]),
            .cur        (cur_q[i]),
            .prev       (prev_q[i])
        );
    end

    tf_start_decode #(.BYTE_W(BYTE_W), .HEAD_W(HEAD_W), .NREG(NR)) u_dec (
        .ext   (cmd_ext),
        .head  (dev_head),
        .cur   (cur_q),
        .prev  (prev_q),
        .lba   (dec_lba),
        .count (dec_cnt)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_ext   <= 1'b0;
            start_lba  <= '0;
            xfer_count <= '0;
            done_lba_q <= '0;
            done_rem_q <= '0;
        end else begin
            if (accept) begin
                mode_ext   <= cmd_ext;
                start_lba  <= dec_lba;
                xfer_count <= dec_cnt;
            end
            if (finish) begin
                done_lba_q <= done_lba;
                done_rem_q <= done_remain;
            end
        end
    end

    assign host_rdata = host_hob ? prev_q[host_sel] : cur_q[host_sel];
endmodule

// File: rtl/tf_addr_regs_chk.sv
module tf_addr_regs_chk #(
    parameter int BYTE_W = tf_pkg::BYTE_W,
    parameter int SEL_W  = 2
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              busy,
    input logic                              cmd_start,
    input logic                              cmd_done,
    input logic                              host_wr,
    input logic [SEL_W-1:0]                  host_sel,
    input logic [BYTE_W-1:0]                 host_wdata,
    input tf_pkg::tf_state_e                 st,
    input logic [(1<<SEL_W)-1:0][BYTE_W-1:0] cur_q,
    input logic [(1<<SEL_W)-1:0][BYTE_W-1:0] prev_q,
    input logic [6*BYTE_W-1:0]               start_lba,
    input logic [2*BYTE_W:0]                 xfer_count
);
    import tf_pkg::*;

    // R2
    host_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && host_wr && !cmd_start) |=>
            (prev_q[$past(host_sel)] == $past(cur_q[host_sel])) &&
            (cur_q[$past(host_sel)] == $past(host_wdata)));

    // R8
    run_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN) |=> ($stable(cur_q) && $stable(prev_q)));

    // R9
    busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_RUN && cmd_done) |=> (st == ST_WRBACK && busy) ##1 (st == ST_IDLE && !busy));

    // R6
    count_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (xfer_count != '0 && xfer_count <= (1 << (2*BYTE_W))));

    // R12
    start_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(start_lba) && $stable(xfer_count)));

    // R12
    idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE && cmd_done && !cmd_start) |=> !busy);
endmodule

bind tf_addr_regs tf_addr_regs_chk #(.BYTE_W(BYTE_W), .SEL_W(SEL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .busy       (busy),
    .cmd_start  (cmd_start),
    .cmd_done   (cmd_done),
    .host_wr    (host_wr),
    .host_sel   (host_sel),
    .host_wdata (host_wdata),
    .st         (st),
    .cur_q      (cur_q),
    .prev_q     (prev_q),
    .start_lba  (start_lba),
    .xfer_count (xfer_count)
);

// File: tb/tf_addr_regs_bench.sv
`timescale 1ns/1ps
module tf_addr_regs_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [1:0]  host_sel = '0;
    logic [7:0]  host_wdata = '0;
    logic        host_hob = 1'b0;
    logic [7:0]  host_rdata;
    logic [3:0]  dev_head = '0;
    logic        cmd_start = 1'b0;
    logic        cmd_ext = 1'b0;
    logic        cmd_done = 1'b0;
    logic [47:0] done_lba = '0;
    logic [15:0] done_remain = '0;
    logic        busy;
    logic [47:0] start_lba;
    logic [16:0] xfer_count;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    tf_addr_regs u_tf_addr_regs (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
        .host_wdata(host_wdata), .host_hob(host_hob), .host_rdata(host_rdata),
        .dev_head(dev_head), .cmd_start(cmd_start), .cmd_ext(cmd_ext),
        .cmd_done(cmd_done), .done_lba(done_lba), .done_remain(done_remain),
        .busy(busy), .start_lba(start_lba), .xfer_count(xfer_count)
    );

    // ext | head | cnt_p cnt_c lo_p lo_c mid_p mid_c hi_p hi_c | exp_lba | exp_cnt
    localparam int VW = 134;
    localparam int NV = 4;
    localparam logic [VW-1:0] VEC [NV] = '{
        {1'b0, 4'hA, 8'h11, 8'h05, 8'h22, 8'h33, 8'h44, 8'h55, 8'h66, 8'h77,
         48'h0000_0A77_5533, 17'd5},
        {1'b0, 4'h3, 8'h12, 8'h00, 8'h01, 8'hFF, 8'h02, 8'hEE, 8'h03, 8'hDD,
         48'h0000_03DD_EEFF, 17'd256},
        {1'b1, 4'hF, 8'h01, 8'h02, 8'h24, 8'h00, 8'h35, 8'h08, 8'h46, 8'h10,
         48'h4635_2410_0800, 17'd258},
        {1'b1, 4'h5, 8'h00, 8'h00, 8'hAB, 8'hCD, 8'h12, 8'h34, 8'hFE, 8'hDC,
         48'hFE12_ABDC_34CD, 17'd65536}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [1:0] sel, input logic [7:0] data);
        @(negedge clk);
        host_wr = 1'b1; host_sel = sel; host_wdata = data;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [1:0] sel, input logic hob, output logic [7:0] data);
        host_sel = sel; host_hob = hob;
        #1;
        data = host_rdata;
    endtask

    task automatic start_cmd(input logic ext, input logic [3:0] head);
        @(negedge clk);
        cmd_start = 1'b1; cmd_ext = ext; dev_head = head;
        @(negedge clk);
        cmd_start = 1'b0;
    endtask

    task automatic end_cmd(input logic [47:0] lba, input logic [15:0] rem);
        @(negedge clk);
        cmd_done = 1'b1; done_lba = lba; done_remain = rem;
        @(negedge clk);
        cmd_done = 1'b0;
        check("R9 busy in write-back", {63'd0, busy}, 64'd1);
        @(negedge clk);
        check("R9 busy released", {63'd0, busy}, 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        logic [VW-1:0] v;
        logic [7:0] b [8];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 busy", {63'd0, busy}, 64'd0);
        check("R1 xfer_count", {47'd0, xfer_count}, 64'd0);
        for (int s = 0; s < 4; s++) begin
            host_read(2'(s), 1'b0, rd); check("R1 cur", {56'd0, rd}, 64'd0);
            host_read(2'(s), 1'b1, rd); check("R1 prev", {56'd0, rd}, 64'd0);
        end

        // Vector table: load, read back, start, write back
        for (int n = 0; n < NV; n++) begin
            v = VEC[n];
            for (int k = 0; k < 8; k++) b[k] = v[128 - 8*k -: 8];
            for (int r = 0; r < 4; r++) begin
                host_write(2'(r), b[2*r]);
                host_write(2'(r), b[2*r+1]);
            end
            for (int r = 0; r < 4; r++) begin
                host_read(2'(r), 1'b0, rd); check("R2 R3 current slot", {56'd0, rd}, {56'd0, b[2*r+1]});
                host_read(2'(r), 1'b1, rd); check("R2 R3 previous slot", {56'd0, rd}, {56'd0, b[2*r]});
            end
            start_cmd(v[133], v[132:129]);
            check("R4 busy after accept", {63'd0, busy}, 64'd1);
            check(v[133] ? "R5 start_lba 48-bit" : "R4 start_lba 28-bit", {16'd0, start_lba}, {16'd0, v[64:17]});
            check(v[133] ? "R7 count 48-bit" : "R6 count 28-bit", {47'd0, xfer_count}, {47'd0, v[16:0]});
            end_cmd(48'h0102_0304_0506, 16'h0708);
            host_read(2'd0, 1'b0, rd); check(v[133] ? "R10 count cur" : "R11 count cur", {56'd0, rd}, 64'h08);
            host_read(2'd1, 1'b0, rd); check(v[133] ? "R10 low cur" : "R11 low cur", {56'd0, rd}, 64'h06);
            host_read(2'd2, 1'b0, rd); check(v[133] ? "R10 mid cur" : "R11 mid cur", {56'd0, rd}, 64'h05);
            host_read(2'd3, 1'b0, rd); check(v[133] ? "R10 high cur" : "R11 high cur", {56'd0, rd}, 64'h04);
            if (v[133]) begin
                host_read(2'd0, 1'b1, rd); check("R10 count prev", {56'd0, rd}, 64'h07);
                host_read(2'd1, 1'b1, rd); check("R10 low prev", {56'd0, rd}, 64'h03);
                host_read(2'd2, 1'b1, rd); check("R10 mid prev", {56'd0, rd}, 64'h02);
                host_read(2'd3, 1'b1, rd); check("R10 high prev", {56'd0, rd}, 64'h01);
            end else begin
                for (int r = 0; r < 4; r++) begin
                    host_read(2'(r), 1'b1, rd); check("R11 prev kept", {56'd0, rd}, {56'd0, b[2*r]});
                end
            end
        end

        // Directed: writes ignored in start cycle and while busy (R8), start held (R12)
        host_write(2'd1, 8'h5A);
        host_write(2'd0, 8'h09);
        @(negedge clk);
        cmd_start = 1'b1; cmd_ext = 1'b0; dev_head = 4'h1;
        host_wr = 1'b1; host_sel = 2'd1; host_wdata = 8'hC3;
        @(negedge clk);
        cmd_start = 1'b0; host_wr = 1'b0;
        host_read(2'd1, 1'b0, rd); check("R8 start-cycle write ignored", {56'd0, rd}, 64'h5A);
        host_write(2'd1, 8'h99);
        host_read(2'd1, 1'b0, rd); check("R8 busy write ignored cur", {56'd0, rd}, 64'h5A);
        host_read(2'd1, 1'b1, rd); check("R8 busy write ignored prev", {56'd0, rd}, 64'h06);
        check("R12 count before restart", {47'd0, xfer_count}, 64'd9);
        host_write(2'd0, 8'h00);
        start_cmd(1'b1, 4'h7);
        check("R12 restart ignored count", {47'd0, xfer_count}, 64'd9);
        check("R12 restart ignored lba", {16'd0, start_lba}, 64'h0000_0000_0104_055A);
        end_cmd(48'h0, 16'h0000);
        host_read(2'd0, 1'b0, rd); check("R11 success count zero", {56'd0, rd}, 64'h00);

        // R12 done while idle has no effect
        @(negedge clk);
        cmd_done = 1'b1;
        @(negedge clk);
        cmd_done = 1'b0;
        check("R12 idle done ignored", {63'd0, busy}, 64'd0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule